// File: doc/BRIEF.md
# Double-Buffered Byte-Loaded Two-Channel Converter Interface

This block is the digital front end of a two-channel 12-bit converter that sits on an 8-bit bus. Each channel keeps a 12-bit staging word. The word is built from two bus writes: a low byte and a high nibble, in either order. The address lines pick the channel and the part. Writes happen only while both the active-low select and the active-low write strobe are asserted.

A separate active-low load strobe moves both staging words into the two output registers in the same cycle. The outputs drive the converter cores. While the load strobe is low, the output registers follow the staging words. When the strobe returns high, they keep the last value.

All strobes arrive asynchronously. They are resynchronized to the system clock with `SYNC_STAGES` flops. The data bus and the address are delayed by the same number of stages, so they stay aligned with the strobes. When a write and a load are both active in one cycle, the freshly written value goes straight through to the output on that edge.

Top module: `byte_dac_if`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), both outputs read 0 and all four staging parts hold 0. A load issued with no prior write therefore leaves both outputs at 0.
- R2: The address selects the part written. Encoding is addr[1] = channel (0 = A, 1 = B) and addr[0] = part (0 = low byte, 1 = high nibble). A write touches only the selected part.
- R3: A staging part is written only in cycles where the synchronized cs_n and wr_n are both low. With either one high, no staging part changes.
- R4: A high-nibble write takes bus bits 3..0 into word bits 11..8. Bus bits 7..4 are ignored. A low-byte write takes bus bits 7..0 into word bits 7..0.
- R5: Low and high parts may be written in either order. Writing one part keeps the value last written to the other part.
- R6: While ld_n stays high, the outputs do not change, whatever is written to the staging words.
- R7: A load updates both outputs from their own channel's staging word on the same clock edge.
- R8: While ld_n is low, the outputs follow the staging words. After ld_n rises, they hold the captured value.
- R9: When a write and a load are active in the same cycle, the output takes the newly written value on the same edge as the staging word. With SYNC_STAGES = 2, an input change made between edges reaches the output at the third following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_d | input | 8 | Data bus, right-justified |
| addr | input | 2 | Channel (bit 1) and part (bit 0) select |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Asynchronous active-low load strobe |
| out_a | output | 12 | Channel A output register |
| out_b | output | 12 | Channel B output register |

## Verification
The bench writes only one part of a word and then loads. This shows whether the other part is kept (a design that cleared or shifted it would load a corrupted word) and whether the top nibble of the bus is masked. It drives the strobe gating one signal at a time: a design that wrote on select alone or on write alone would change a staging word that should have stayed put. It also watches both outputs cycle by cycle during a load. A design that updated the channels on different edges, or that skipped forwarding a write made during a load, would show a skewed or one-cycle-late output.

// File: rtl/dac_if_pkg.sv
// Package: shared constants and part encoding for the byte-loaded
// two-channel converter interface. Assumes exactly two channels
// addressed by one address bit.
package dac_if_pkg;
    localparam int NCH = 2;
    typedef enum logic {PART_LO = 1'b0, PART_HI = 1'b1} part_e;
endpackage

// File: rtl/sync_pipe.sv
// sync_pipe: a STAGES-deep register chain. Used both as a synchronizer
// for asynchronous strobes and as a matching delay line for data.
// Assumes STAGES >= 1; reset loads RST_VAL into every stage.
module sync_pipe #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each later stage copies its predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/chan_input.sv
// chan_input: staging word of one channel, built from a low byte and
// a high nibble. Presents the registered word and its next-state value,
// so a simultaneous load can forward it. Assumes HI_W <= DATA_W and
// that wr_act and addr are already synchronous to clk.
module chan_input
    import dac_if_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HI_W = 4,
    parameter int CH_ID = 0,
    localparam int WORD_W = DATA_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_act,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] bus,
    output logic [WORD_W-1:0] word_q,
    output logic [WORD_W-1:0] word_d
);
    logic [DATA_W-1:0] lo_q, lo_d;
    logic [HI_W-1:0]   hi_q, hi_d;
    logic              sel, wr_lo, wr_hi;

    // Decode channel and part from the address during an active write.
    always_comb begin
        sel   = wr_act && (addr[1] == CH_ID[0]);
        wr_lo = sel && (part_e'(addr[0]) == PART_LO);
        wr_hi = sel && (part_e'(addr[0]) == PART_HI);
    end

    // Next-state values: selected part takes the bus, right-justified.
    always_comb begin
        lo_d   = wr_lo ? bus : lo_q;
        hi_d   = wr_hi ? bus[HI_W-1:0] : hi_q;
        word_d = {hi_d, lo_d};
    end

    // Staging registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign word_q = {hi_q, lo_q};

    // R3: no write strobe, no change to the staging word
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_act |=> $stable(word_q));
    // R2: the low byte moves only when it is addressed
    a_r2_lo_only_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && addr != {CH_ID[0], 1'b0}) |=> $stable(lo_q));
    // R2: the high nibble moves only when it is addressed
    a_r2_hi_only_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && addr != {CH_ID[0], 1'b1}) |=> $stable(hi_q));
    // R4: high nibble takes the low bus bits
    a_r4_hi_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_act && addr == {CH_ID[0], 1'b1}) |=> hi_q == $past(bus[HI_W-1:0]));
endmodule

// File: rtl/out_reg.sv
// out_reg: output register of one channel. Follows its input while the
// synchronized load is active and holds otherwise. Assumes ld_act is
// synchronous to clk.
module out_reg #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_act,
    input  logic [WORD_W-1:0] word_d,
    output logic [WORD_W-1:0] out_q
);
    // Transparent-while-low behaviour, sampled on the clock.
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (ld_act) out_q <= word_d;
    end

    // R6: no load, output holds
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_act |=> $stable(out_q));
    // R1: reset clears the output
    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> out_q == '0);
endmodule

// File: rtl/byte_dac_if.sv
// byte_dac_if: top of the double-buffered, byte-loaded two-channel
// converter interface. Resynchronizes the strobes, delays the bus and
// address to match, builds the two staging words and transfers them
// together on load. Assumes the bus and address are stable while a
// write is asserted.
module byte_dac_if
    import dac_if_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int HI_W = 4,
    parameter int SYNC_STAGES = 2,
    localparam int WORD_W = DATA_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_d,
    input  logic [1:0]        addr,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              ld_n,
    output logic [WORD_W-1:0] out_a,
    output logic [WORD_W-1:0] out_b
);
    logic [2:0]        strb_s;
    logic [DATA_W+1:0] data_s;
    logic              wr_act, ld_act;
    logic [WORD_W-1:0] word_q [NCH];
    logic [WORD_W-1:0] word_d [NCH];
    logic [WORD_W-1:0] out_w  [NCH];

    sync_pipe #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strb_sync (
        .clk(clk), .rst_n(rst_n), .d({ld_n, cs_n, wr_n}), .q(strb_s)
    );

    sync_pipe #(.W(DATA_W+2), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_dly (
        .clk(clk), .rst_n(rst_n), .d({addr, bus_d}), .q(data_s)
    );

    // Active-high synchronized write and load qualifiers.
    always_comb begin
        wr_act = !strb_s[1] && !strb_s[0];
        ld_act = !strb_s[2];
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            chan_input #(.DATA_W(DATA_W), .HI_W(HI_W), .CH_ID(c)) u_in (
                .clk(clk), .rst_n(rst_n), .wr_act(wr_act),
                .addr(data_s[DATA_W+1:DATA_W]), .bus(data_s[DATA_W-1:0]),
                .word_q(word_q[c]), .word_d(word_d[c])
            );
            out_reg #(.WORD_W(WORD_W)) u_out (
                .clk(clk), .rst_n(rst_n), .ld_act(ld_act),
                .word_d(word_d[c]), .out_q(out_w[c])
            );
            // R9 / R7: on load the output equals the updated staging word
            a_r9_forward: assert property (@(posedge clk) disable iff (!rst_n)
                ld_act |=> out_w[c] == word_q[c]);
        end
    endgenerate

    assign out_a = out_w[0];
    assign out_b = out_w[1];
endmodule

// File: tb/byte_dac_if_tb.sv
module byte_dac_if_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_d = '0;
    logic [1:0]  addr = '0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        ld_n = 1'b1;
    logic [11:0] out_a, out_b;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [11:0] in_a = '0, in_b = '0, ex_a = '0, ex_b = '0;

    byte_dac_if u_dut (
        .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .addr(addr),
        .cs_n(cs_n), .wr_n(wr_n), .ld_n(ld_n), .out_a(out_a), .out_b(out_b)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bench model of a staging write (R2, R4).
    task automatic model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'b00: in_a[7:0]  = d;
            2'b01: in_a[11:8] = d[3:0];
            2'b10: in_b[7:0]  = d;
            2'b11: in_b[11:8] = d[3:0];
        endcase
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d,
                             input logic cs, input logic wr);
        @(negedge clk);
        addr = a; bus_d = d; cs_n = cs; wr_n = wr;
        idle(2);
        cs_n = 1'b1; wr_n = 1'b1;
        idle(4);
        if (!cs && !wr) model_write(a, d);
    endtask

    task automatic load_pulse();
        @(negedge clk);
        ld_n = 1'b0;
        idle(2);
        ld_n = 1'b1;
        idle(5);
        ex_a = in_a; ex_b = in_b;
    endtask

    task automatic t_reset();
        check("R1 reset out_a", out_a, 12'h000);
        check("R1 reset out_b", out_b, 12'h000);
        load_pulse();
        check("R1 cleared staging a", out_a, 12'h000);
        check("R1 cleared staging b", out_b, 12'h000);
    endtask

    task automatic t_decode();
        bus_write(2'b00, 8'h34, 1'b0, 1'b0);
        bus_write(2'b01, 8'h12, 1'b0, 1'b0);
        bus_write(2'b10, 8'hCD, 1'b0, 1'b0);
        bus_write(2'b11, 8'h0B, 1'b0, 1'b0);
        check("R6 no load a", out_a, 12'h000);
        check("R6 no load b", out_b, 12'h000);
        load_pulse();
        check("R2 decode a", out_a, 12'h234);
        check("R2 decode b", out_b, 12'hBCD);
    endtask

    task automatic t_nibble();
        bus_write(2'b01, 8'hF5, 1'b0, 1'b0);
        load_pulse();
        check("R4 nibble mask a", out_a, 12'h534);
        bus_write(2'b00, 8'h99, 1'b0, 1'b0);
        load_pulse();
        check("R5 low keeps high a", out_a, 12'h599);
        check("R2 other channel kept b", out_b, 12'hBCD);
    endtask

    task automatic t_gate();
        bus_write(2'b00, 8'h00, 1'b1, 1'b0);
        bus_write(2'b10, 8'h00, 1'b0, 1'b1);
        bus_write(2'b11, 8'h0F, 1'b1, 1'b1);
        load_pulse();
        check("R3 gated a", out_a, 12'h599);
        check("R3 gated b", out_b, 12'hBCD);
    endtask

    task automatic t_order();
        bus_write(2'b11, 8'h07, 1'b0, 1'b0);
        bus_write(2'b10, 8'h11, 1'b0, 1'b0);
        check("R6 hold before load b", out_b, 12'hBCD);
        load_pulse();
        check("R5 high first b", out_b, 12'h711);
        check("R5 a unchanged", out_a, 12'h599);
    endtask

    task automatic t_together();
        int ca = -1, cb = -1;
        logic [11:0] pa, pb;
        bus_write(2'b00, 8'h66, 1'b0, 1'b0);
        bus_write(2'b10, 8'h77, 1'b0, 1'b0);
        pa = out_a; pb = out_b;
        @(negedge clk);
        ld_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 1) ld_n = 1'b1;
            if (ca < 0 && out_a != pa) ca = i;
            if (cb < 0 && out_b != pb) cb = i;
        end
        ex_a = in_a; ex_b = in_b;
        check("R7 same edge", 12'(ca), 12'(cb));
        check("R7 load a", out_a, 12'h566);
        check("R7 load b", out_b, 12'h777);
    endtask

    task automatic t_transparent();
        @(negedge clk);
        ld_n = 1'b0;
        idle(4);
        addr = 2'b00; bus_d = 8'h42; cs_n = 1'b0; wr_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 not before third edge", out_a, 12'h566);
        @(posedge clk); @(negedge clk);
        check("R9 forward on third edge", out_a, 12'h542);
        cs_n = 1'b1; wr_n = 1'b1;
        model_write(2'b00, 8'h42);
        idle(4);
        ld_n = 1'b1;
        idle(4);
        bus_write(2'b00, 8'h00, 1'b0, 1'b0);
        check("R8 hold after release a", out_a, 12'h542);
        check("R8 hold after release b", out_b, 12'h777);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_decode();
        t_nibble();
        t_gate();
        t_order();
        t_together();
        t_transparent();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule